// File: doc/BRIEF.md
# Selectable-Clock Countdown and Watchdog Timer

This block is an 8-bit down-counter that advances on one of eight pre-divided tick strobes, the one named by a 3-bit source field. A 2-bit mode field turns the timer off, runs it as a repeating countdown, or runs it as a one-shot watchdog. Software writes a byte to a value register to load the counter and the reload value. With the 1 Hz strobe selected, a load of N expires N seconds later. The live count is always visible, so software can work out how much time is left.

On expiry an expiry flag is set. A strobe from the register interface reports that the flag has been read, and the flag then clears by itself. An interrupt enable gates the interrupt output. That output either follows the flag as a steady level or gives a pulse that lasts one selected-tick period.

The tick strobes are produced outside the block. Each strobe is one clock cycle long.

Top module: `wdt_timer`

## Requirements
- R1: After reset the count is 0, the flag is clear, the interrupt output is low, and the configuration is all zeros (mode off, source 0, level output, interrupt disabled).
- R2: In mode 00 (off) and in the unused mode 11, the count does not change on ticks and no expiry occurs.
- R3: Only the strobe whose index equals the source field (configuration bits [4:2]) moves the counter. Encoding 010 selects tick_i[2], which is the 1 Hz strobe. Strobes on any other index have no effect.
- R4: A write with wr_addr=1 loads both the count and the reload value with wr_data in the next cycle, and takes priority over a tick in the same cycle. Each later selected tick in an active mode lowers the count by one. The tick that takes the count from 1 to 0 is the expiry, so a load of N expires on the Nth selected tick.
- R5: In watchdog mode (mode 10), the count stays at 0 after expiry, and further ticks have no effect until the next load.
- R6: In countdown mode (mode 01), expiry reloads the count from the reload value in the same cycle, so expiries repeat every N selected ticks.
- R7: Expiry sets the flag (flag_o) in the next cycle. A one-cycle flag_rd_i strobe clears the flag in the next cycle. An expiry in the same cycle as the strobe leaves the flag set.
- R8: With the interrupt-enable bit (configuration bit 6) at 0, irq_o stays low whatever the state of the flag or the pulse.
- R9: With the output-style bit (configuration bit 5) at 0, irq_o equals the flag gated by the enable.
- R10: With the output-style bit at 1, irq_o goes high in the cycle after expiry and falls in the cycle after the next selected tick, whether or not the flag has been read.
- R11: A load of 0 never produces an expiry. The count stays at 0 in both active modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 8 | Pre-divided one-cycle tick strobes, one per source index |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the configuration register, 1 selects the value register |
| wr_data | input | 8 | Write data. For the configuration register: [1:0] mode, [4:2] source, [5] pulsed output, [6] interrupt enable |
| flag_rd_i | input | 1 | Strobe that reports a read of the flag register |
| count_o | output | 8 | Current count |
| flag_o | output | 1 | Expiry flag |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume that tick, write and read inputs are one-cycle strobes that change only away from the rising edge. They also assume that a configuration write may land in the same cycle as an expiry, which is why the interrupt properties exclude that cycle. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It separates selected ticks with idle cycles, so a pulsed interrupt is visible for several cycles before it falls. It also places a read strobe on the same cycle as an expiry, to exercise the rule that a set takes priority over a clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SRC_W = 3;
  localparam int N_SRC = 1 << SRC_W;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_COUNT = 2'b01,
    TM_WATCH = 2'b10,
    TM_RSVD  = 2'b11
  } tmode_e;

  typedef struct packed {
    logic             ie;
    logic             pulsed;
    logic [SRC_W-1:0] src;
    tmode_e           mode;
  } tcfg_t;

  localparam int CFG_W = $bits(tcfg_t);

  function automatic logic mode_runs(input tmode_e m);
    return (m == TM_COUNT) || (m == TM_WATCH);
  endfunction
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int N_SRC = 8,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = ticks[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             auto_reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rel_q;

  function automatic logic [CNT_W-1:0] after_tick(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic             again
  );
    if (cur == CNT_W'(1)) return again ? rel : '0;
    return cur - CNT_W'(1);
  endfunction

  assign expire = step && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      rel_q <= load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= after_tick(cnt_q, rel_q, auto_reload);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdt_irq.sv
module wdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic sel_tick,
  input  logic rd_clr,
  input  logic ie,
  input  logic pulsed,
  output logic flag,
  output logic irq
);
  logic flag_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (expire)      flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
      if (expire)        pulse_q <= 1'b1;
      else if (sel_tick) pulse_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign irq  = ie && (pulsed ? pulse_q : flag_q);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_rd_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              irq_o
);
  tcfg_t cfg_q;
  logic  cfg_wr;
  logic  val_wr;
  logic  sel_tick;
  logic  active;
  logic  watch;
  logic  step;
  logic  expire;

  assign cfg_wr = wr_en && !wr_addr;
  assign val_wr = wr_en && wr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= tcfg_t'(wr_data[CFG_W-1:0]);
  end

  assign active = mode_runs(cfg_q.mode);
  assign watch  = (cfg_q.mode == TM_WATCH);

  wdt_tick_sel #(.N_SRC(N_SRC)) i_sel (
    .ticks (tick_i),
    .sel   (cfg_q.src),
    .tick  (sel_tick)
  );

  assign step = active && sel_tick;

  wdt_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (val_wr),
    .load_val    (wr_data),
    .step        (step),
    .auto_reload (cfg_q.mode == TM_COUNT),
    .count       (count_o),
    .expire      (expire)
  );

  wdt_irq i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .sel_tick (sel_tick),
    .rd_clr   (flag_rd_i),
    .ie       (cfg_q.ie),
    .pulsed   (cfg_q.pulsed),
    .flag     (flag_o),
    .irq      (irq_o)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             active,
  input logic             watch,
  input logic             expire,
  input logic             val_wr,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic             rd,
  input logic             ie,
  input logic             pulsed,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             irq
);
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> (cnt == $past(wr_data)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !val_wr && (cnt > CNT_W'(1))) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !val_wr) |=> $stable(cnt));

  assert_wstop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (watch && expire) |=> (cnt == '0));

  assert_flagset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_flagclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !expire) |=> !flag);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !cfg_wr) |=> !irq);

  assert_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulsed && ie && expire && !cfg_wr) |=> irq);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulsed && ie && expire && !cfg_wr) |=> irq);

  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !expire);
endmodule

bind wdt_timer wdt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step    (step),
  .active  (active),
  .watch   (watch),
  .expire  (expire),
  .val_wr  (val_wr),
  .cfg_wr  (cfg_wr),
  .wr_data (wr_data),
  .rd      (flag_rd_i),
  .ie      (cfg_q.ie),
  .pulsed  (cfg_q.pulsed),
  .cnt     (count_o),
  .flag    (flag_o),
  .irq     (irq_o)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tick_i = '0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       flag_rd_i = 1'b0;
  logic [7:0] count_o;
  logic       flag_o;
  logic       irq_o;

  always #(CLK_P/2) clk = ~clk;

  wdt_timer i_wdt_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag_rd_i(flag_rd_i),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       flag;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  string tag = "R1";

  // reference state built from the requirements
  logic [7:0] m_cnt = 0, m_rel = 0;
  logic       m_flag = 0, m_pulse = 0;
  logic [1:0] m_mode = 0;
  logic [2:0] m_src = 0;
  logic       m_pul = 0, m_ie = 0;

  task automatic cyc(input logic [7:0] tk, input logic rd,
                     input logic wr, input logic a, input logic [7:0] d);
    logic sel, run, fire;
    exp_t e;
    @(negedge clk);
    tick_i = tk; flag_rd_i = rd; wr_en = wr; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    tick_i = '0; flag_rd_i = 0; wr_en = 0; wr_addr = 0; wr_data = '0;
    sel  = tk[m_src];
    run  = (m_mode == 2'b01) || (m_mode == 2'b10);
    fire = run && sel && (m_cnt == 8'd1) && !(wr && a);
    if (wr && a) begin
      m_cnt = d; m_rel = d;
    end else if (run && sel && m_cnt != 0) begin
      if (m_cnt == 1) m_cnt = (m_mode == 2'b01) ? m_rel : 8'd0;
      else m_cnt = m_cnt - 1;
    end
    if (fire) m_flag = 1; else if (rd) m_flag = 0;
    if (fire) m_pulse = 1; else if (sel) m_pulse = 0;
    if (wr && !a) begin
      m_mode = d[1:0]; m_src = d[4:2]; m_pul = d[5]; m_ie = d[6];
    end
    e.cnt = m_cnt; e.flag = m_flag;
    e.irq = m_ie & (m_pul ? m_pulse : m_flag);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 0, 0, 0, 8'h00);
  endtask

  task automatic cfg(input logic [1:0] mode, input logic [2:0] src,
                     input logic pul, input logic ie);
    cyc(8'h00, 0, 1, 0, {1'b0, ie, pul, src, mode});
  endtask

  task automatic ld(input logic [7:0] v);
    cyc(8'h00, 0, 1, 1, v);
  endtask

  task automatic ticks(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(8'h01 << idx, 0, 0, 0, 8'h00);
      idle(2);
    end
  endtask

  task automatic rd_flag();
    cyc(8'h00, 1, 0, 0, 8'h00);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (count_o !== e.cnt || flag_o !== e.flag || irq_o !== e.irq) begin
        n_bad++;
        $display("FAIL %s: count/flag/irq got %h/%b/%b expected %h/%b/%b",
                 e.tag, count_o, flag_o, irq_o, e.cnt, e.flag, e.irq);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tag = "R1"; idle(3);
    // R2: off and reserved modes hold the count
    tag = "R2"; ld(8'd3); ticks(0, 3);
    cfg(2'b11, 3'd0, 0, 1); ticks(0, 3);
    // R3: source 010, other strobes ignored
    tag = "R3"; cfg(2'b10, 3'b010, 0, 1); ld(8'd3);
    ticks(0, 2); ticks(5, 2); ticks(7, 1);
    tag = "R4"; ticks(2, 2);
    tag = "R9"; ticks(2, 1); idle(2);
    tag = "R5"; ticks(2, 3);
    tag = "R7"; rd_flag(); idle(2);
    // R8: enable off masks the output
    tag = "R8"; cfg(2'b10, 3'b010, 0, 0); ld(8'd1); ticks(2, 1); idle(2);
    rd_flag(); idle(1);
    // R6 and R10: countdown, pulsed, source 7
    tag = "R6"; cfg(2'b01, 3'd7, 1, 1); ld(8'd2);
    ticks(7, 4);
    tag = "R10"; ticks(7, 1); rd_flag(); idle(2); ticks(7, 1);
    tag = "R7"; rd_flag(); ticks(7, 1);
    cyc(8'h80, 1, 0, 0, 8'h00); idle(2);
    rd_flag(); idle(1);
    tag = "R4"; cyc(8'h80, 0, 1, 1, 8'd5); idle(1); ticks(7, 2);
    // R11: zero load
    tag = "R11"; ld(8'd0); ticks(7, 3);
    cfg(2'b10, 3'd7, 0, 1); ticks(7, 2);
    idle(2);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule